// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

The block gathers eight interrupt request lines, latches each rising edge into a request register and filters it through an 8-bit mask. It compares the best unmasked request against the levels already being serviced. When the new request ranks higher, it raises a single interrupt line to the CPU. The CPU answers with an acknowledge pulse. The controller then marks the winning level as in service, clears its request, and returns a 16-bit vector address on a valid/ready output stream. Software finishes a handler with an end-of-interrupt command.

Priority order can be changed at run time, and there are four ways to set it:
- fixed order, with level 0 first;
- rotation, where a serviced level drops to the bottom;
- software-named lowest level, with the other levels following it in numeric order;
- polling, where no interrupt is driven and software reads a status word instead.

The vector comes from a relocatable table base. Table entries are spaced 4 or 8 bytes apart.

A small byte-wide register port controls the block. It has four addresses:
- Address 0 takes commands. A read at address 0 returns the request register, the in-service register, or the poll word.
- Address 1 holds the mask.
- Address 2 holds the low byte of the table base.
- Address 3 holds the high byte of the table base.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A request bit is set by a rising edge on its input line, with the register updated at the first clock edge after the rise. A line held high sets nothing further. The bit stays set until that level is acknowledged.
- R2: A byte written to address 1 becomes the mask and reads back unchanged. A masked level never raises `irq_out`. Its request bit is kept and fires once the mask bit is cleared.
- R3: In fixed mode (command byte 0x80), level 0 ranks highest and level 7 lowest. `irq_out` is high only when the best pending unmasked level ranks strictly above every in-service level.
- R4: An `ack_req` sampled while `irq_out` is high has three effects at that edge: it sets the winner's in-service bit, clears its request bit, and raises `vec_valid`. The vector is then presented from the next cycle.
- R5: With spacing 4 (command bit 2 = 0), the vector is the base with bits 4:0 cleared, ORed with level·4.
- R6: With spacing 8 (command bit 2 = 1), the vector is the base with bits 5:0 cleared, ORed with level·8.
- R7: While `vec_valid` is high and `vec_ready` is low, `vec_valid` and `vec_data` hold steady. `irq_out` stays low and further acknowledges are ignored. The vector is consumed on the edge where `vec_valid` and `vec_ready` are both high.
- R8: In rotating mode (command 0x81), the level cleared by an end-of-interrupt becomes the lowest priority. The ranking restarts just above it.
- R9: In specific mode (command 0x80 | L<<4 | 0x02), level L ranks lowest and L+1 ranks highest, with the other levels in numeric order after it.
- R10: In polled mode (command 0x83), `irq_out` stays low. A read at address 0 returns bit 7 set when an unmasked request is pending, with the best pending level in bits 2:0. That read also acts as an acknowledge.
- R11: Command 0x00 clears the highest-ranked in-service bit. Command 0x01 | L<<4 clears in-service bit L.
- R12: Outside polled mode, a read at address 0 returns the request register after command 0x02 and the in-service register after command 0x06. The request register is the default after reset.
- R13: After reset, the following hold:
  - the mask, request and in-service registers are all zero;
  - the mode is fixed priority with spacing 4;
  - `irq_out` and `vec_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, edge sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read in polled mode has a side effect) |
| reg_addr | input | 2 | Register address: 0 command/status, 1 mask, 2 base low, 3 base high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq_out | output | 1 | Interrupt request to the CPU |
| ack_req | input | 1 | Interrupt acknowledge from the CPU |
| vec_valid | output | 1 | Vector stream valid |
| vec_ready | input | 1 | Vector stream ready |
| vec_data | output | 16 | Vector address |

## Verification
Each result has a fixed latency:
- A request edge driven before a clock edge is in the request register after that edge. From then on, `irq_out` and the read-back show it.
- An acknowledge raises `vec_valid` one edge later, with the vector already correct.
- Register writes and command effects are visible after the edge that samples the strobe.
- The poll word is combinational in the read cycle itself, and the acknowledge that the poll read performs takes effect at the closing edge.

The bench drives inputs at falling edges and samples outputs at the next falling edge. Reads are sampled 1 ns into the strobe cycle, so every check falls in the first cycle where the result is due.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  typedef enum logic [1:0] {
    MODE_NEST = 2'd0,
    MODE_ROT  = 2'd1,
    MODE_SPEC = 2'd2,
    MODE_POLL = 2'd3
  } prio_mode_e;

  localparam int VEC_W = 16;

  localparam logic [1:0] A_CMD   = 2'd0;
  localparam logic [1:0] A_MASK  = 2'd1;
  localparam logic [1:0] A_BASEL = 2'd2;
  localparam logic [1:0] A_BASEH = 2'd3;

  localparam logic [1:0] OP_EOI_ANY = 2'd0;
  localparam logic [1:0] OP_EOI_LVL = 2'd1;
  localparam logic [1:0] OP_SEL     = 2'd2;

endpackage

// File: rtl/prio_irq_edge.sv
module prio_irq_edge #(
  parameter int NLVL = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] line_i,
  output logic [NLVL-1:0] rise_o
);
  for (genvar g = 0; g < NLVL; g++) begin : g_line
    logic prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= line_i[g];
    end
    assign rise_o[g] = line_i[g] & ~prev_q;
  end
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
  parameter int NLVL = 8,
  localparam int LW = $clog2(NLVL)
) (
  input  logic [NLVL-1:0] bits_i,
  input  logic [LW-1:0]   low_i,
  output logic            hit_o,
  output logic [LW-1:0]   lvl_o,
  output logic [LW-1:0]   rank_o
);
  // Rank 0 is the level just above low_i; the loop runs from the worst
  // rank down so the best hit is assigned last.
  always_comb begin
    hit_o  = 1'b0;
    lvl_o  = '0;
    rank_o = '0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      logic [LW-1:0] cand;
      cand = low_i + LW'(1) + LW'(i);
      if (bits_i[cand]) begin
        hit_o  = 1'b1;
        lvl_o  = cand;
        rank_o = LW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_vec.sv
module prio_irq_vec #(
  parameter int NLVL = 8,
  localparam int LW = $clog2(NLVL),
  localparam int VW = prio_irq_pkg::VEC_W
) (
  input  logic [VW-1:0] base_i,
  input  logic          wide_i,
  input  logic [LW-1:0] lvl_i,
  output logic [VW-1:0] vec_o
);
  logic [VW-1:0] low_mask;
  int            step_sh;

  always_comb begin
    step_sh  = wide_i ? 3 : 2;
    low_mask = (VW'(1) << (LW + step_sh)) - VW'(1);
    vec_o    = (base_i & ~low_mask) | (VW'(lvl_i) << step_sh);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NLVL = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  irq_in,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq_out,
  input  logic        ack_req,
  output logic        vec_valid,
  input  logic        vec_ready,
  output logic [15:0] vec_data
);
  localparam int LW = $clog2(NLVL);
  localparam logic [LW-1:0] LOW_DEF = LW'(NLVL - 1);

  prio_mode_e        mode_q;
  logic              wide_q;
  logic              sel_isr_q;
  logic [LW-1:0]     low_q;
  logic [NLVL-1:0]   mask_q, irr_q, isr_q, irr_n, isr_n, rise;
  logic [VEC_W-1:0]  base_q, vec_q, vec_calc;
  logic              vec_valid_q;

  logic              p_hit, s_hit;
  logic [LW-1:0]     p_lvl, p_rank, s_lvl, s_rank;
  logic              win_ok, ack_fire, poll_fire, take;
  logic              cmd_wr, cmd_cfg, eoi_any, eoi_lvl_cmd, sel_cmd, eoi_go;
  logic [LW-1:0]     cmd_lvl, eoi_lvl;
  logic              cmd_unused;

  assign cmd_unused = reg_wdata[3];

  prio_irq_edge #(.NLVL(NLVL)) u_edge (
    .clk(clk), .rst_n(rst_n), .line_i(irq_in[NLVL-1:0]), .rise_o(rise)
  );

  prio_irq_pick #(.NLVL(NLVL)) u_pick_req (
    .bits_i(irr_q & ~mask_q), .low_i(low_q),
    .hit_o(p_hit), .lvl_o(p_lvl), .rank_o(p_rank)
  );

  prio_irq_pick #(.NLVL(NLVL)) u_pick_svc (
    .bits_i(isr_q), .low_i(low_q),
    .hit_o(s_hit), .lvl_o(s_lvl), .rank_o(s_rank)
  );

  prio_irq_vec #(.NLVL(NLVL)) u_vec (
    .base_i(base_q), .wide_i(wide_q), .lvl_i(p_lvl), .vec_o(vec_calc)
  );

  // Priority resolution and acknowledge
  assign win_ok    = p_hit && (!s_hit || (p_rank < s_rank));
  assign irq_out   = win_ok && (mode_q != MODE_POLL) && !vec_valid_q;
  assign ack_fire  = ack_req && irq_out;
  assign poll_fire = reg_rd && (reg_addr == A_CMD) && (mode_q == MODE_POLL) && p_hit;
  assign take      = ack_fire || poll_fire;

  // Command decode
  assign cmd_wr      = reg_wr && (reg_addr == A_CMD);
  assign cmd_cfg     = cmd_wr && reg_wdata[7];
  assign cmd_lvl     = reg_wdata[4 +: LW];
  assign eoi_any     = cmd_wr && !reg_wdata[7] && (reg_wdata[1:0] == OP_EOI_ANY);
  assign eoi_lvl_cmd = cmd_wr && !reg_wdata[7] && (reg_wdata[1:0] == OP_EOI_LVL);
  assign sel_cmd     = cmd_wr && !reg_wdata[7] && (reg_wdata[1:0] == OP_SEL);
  assign eoi_lvl     = eoi_any ? s_lvl : cmd_lvl;
  assign eoi_go      = (eoi_any && s_hit) || (eoi_lvl_cmd && isr_q[cmd_lvl]);

  always_comb begin
    isr_n = isr_q;
    if (eoi_go) isr_n[eoi_lvl] = 1'b0;
    if (take)   isr_n[p_lvl]   = 1'b1;
    irr_n = irr_q;
    if (take)   irr_n[p_lvl]   = 1'b0;
    irr_n = irr_n | rise;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MODE_NEST;
      wide_q      <= 1'b0;
      sel_isr_q   <= 1'b0;
      low_q       <= LOW_DEF;
      mask_q      <= '0;
      base_q      <= '0;
      irr_q       <= '0;
      isr_q       <= '0;
      vec_valid_q <= 1'b0;
      vec_q       <= '0;
    end else begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      if (reg_wr) begin
        case (reg_addr)
          A_MASK:  mask_q       <= reg_wdata[NLVL-1:0];
          A_BASEL: base_q[7:0]  <= reg_wdata;
          A_BASEH: base_q[15:8] <= reg_wdata;
          default: ;
        endcase
      end
      if (cmd_cfg) begin
        mode_q <= prio_mode_e'(reg_wdata[1:0]);
        wide_q <= reg_wdata[2];
        low_q  <= (prio_mode_e'(reg_wdata[1:0]) == MODE_SPEC) ? cmd_lvl : LOW_DEF;
      end else if (eoi_go && mode_q == MODE_ROT) begin
        low_q <= eoi_lvl;
      end
      if (sel_cmd) sel_isr_q <= reg_wdata[2];
      if (vec_valid_q && vec_ready) vec_valid_q <= 1'b0;
      if (ack_fire) begin
        vec_valid_q <= 1'b1;
        vec_q       <= vec_calc;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CMD: begin
        if (mode_q == MODE_POLL) begin
          reg_rdata[7]    = p_hit;
          reg_rdata[LW-1:0] = p_lvl;
        end else if (sel_isr_q) begin
          reg_rdata[NLVL-1:0] = isr_q;
        end else begin
          reg_rdata[NLVL-1:0] = irr_q;
        end
      end
      A_MASK:  reg_rdata[NLVL-1:0] = mask_q;
      A_BASEL: reg_rdata = base_q[7:0];
      default: reg_rdata = base_q[15:8];
    endcase
  end

  assign vec_valid = vec_valid_q;
  assign vec_data  = vec_q;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
#(
  parameter int NLVL = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [1:0]      reg_addr,
  input logic [7:0]      reg_wdata,
  input logic            ack_req,
  input logic            irq_out,
  input logic            vec_valid,
  input logic            vec_ready,
  input logic [15:0]     vec_data,
  input logic [1:0]      mode_q,
  input logic [NLVL-1:0] mask_q,
  input logic [NLVL-1:0] irr_q,
  input logic [NLVL-1:0] isr_q
);
  assert_poll_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_POLL) |-> !irq_out);

  assert_irq_has_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((irr_q & ~mask_q) != '0));

  assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MASK) |=> (mask_q == $past(reg_wdata[NLVL-1:0])));

  assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data)));

  assert_vec_blocks_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !irq_out);

  assert_ack_marks_svc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && irq_out && !(reg_wr && reg_addr == A_CMD))
      |=> (vec_valid && ($countones(isr_q) == $past($countones(isr_q)) + 1)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NLVL(NLVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ack_req(ack_req), .irq_out(irq_out),
  .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
  .mode_q(mode_q), .mask_q(mask_q), .irr_q(irr_q), .isr_q(isr_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_in = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_out, ack_req = 1'b0, vec_valid, vec_ready = 1'b1;
  logic [15:0] vec_data;
  int n_chk = 0, n_fail = 0;

  localparam logic [15:0] BASE = 16'h1240;
  // {mask, requests, expect irq, expected level}
  localparam logic [19:0] TBL [6] = '{
    {8'h00, 8'h01, 1'b1, 3'd0},
    {8'h00, 8'hA0, 1'b1, 3'd5},
    {8'h01, 8'h03, 1'b1, 3'd1},
    {8'hFF, 8'h10, 1'b0, 3'd0},
    {8'h0F, 8'h90, 1'b1, 3'd4},
    {8'h00, 8'h80, 1'b1, 3'd7}
  };

  always #4 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .ack_req(ack_req), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_data(vec_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic ack();
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
  endtask

  task automatic drain();
    wr(1, 8'h00);
    for (int k = 0; k < 8; k++) begin
      if (irq_out) ack();
      wr(0, 8'h00);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 irq_out", irq_out, 0);
    chk("R13 vec_valid", vec_valid, 0);
    rd(1, d); chk("R13 mask", d, 8'h00);
    rd(0, d); chk("R13 requests", d, 8'h00);

    wr(2, BASE[7:0]); wr(3, BASE[15:8]);
    rd(3, d); chk("R5 base high", d, BASE[15:8]);

    // Table walk: fixed priority with masks (R2, R3, R5)
    for (int i = 0; i < 6; i++) begin
      wr(1, TBL[i][19:12]);
      rd(1, d); chk("R2 mask readback", d, TBL[i][19:12]);
      set_irq(TBL[i][11:4]);
      chk("R2/R3 irq", irq_out, TBL[i][3]);
      if (TBL[i][3]) begin
        ack();
        chk("R5 vector", vec_data, BASE | (16'(TBL[i][2:0]) << 2));
        wr(0, 8'h00);
      end
      set_irq(8'h00);
      drain();
    end

    // R1: held line does not re-request; new edge does
    set_irq(8'h04); ack(); wr(0, 8'h00);
    @(negedge clk);
    chk("R1 held line quiet", irq_out, 0);
    rd(0, d); chk("R1 request cleared", d, 8'h00);
    set_irq(8'h00); set_irq(8'h04);
    chk("R1 new edge", irq_out, 1);
    drain(); set_irq(8'h00);

    // R3 nesting, R11 end-of-interrupt, R12 readback select
    set_irq(8'h08); ack();
    set_irq(8'h28);
    chk("R3 lower blocked", irq_out, 0);
    set_irq(8'h2A);
    chk("R3 higher passes", irq_out, 1);
    ack(); chk("R4 vector level 1", vec_data, BASE | 16'h0004);
    wr(0, 8'h06); rd(0, d); chk("R12 in-service", d, 8'h0A);
    wr(0, 8'h00); rd(0, d); chk("R11 any eoi", d, 8'h08);
    wr(0, 8'h31); rd(0, d); chk("R11 level eoi", d, 8'h00);
    wr(0, 8'h02); rd(0, d); chk("R12 requests", d, 8'h20);
    chk("R3 pending after eoi", irq_out, 1);
    drain(); set_irq(8'h00);

    // R7 back-pressure
    vec_ready = 1'b0;
    set_irq(8'h01); ack();
    chk("R7 valid", vec_valid, 1);
    @(negedge clk); @(negedge clk);
    chk("R7 still valid", vec_valid, 1);
    chk("R7 data stable", vec_data, BASE);
    chk("R7 irq low", irq_out, 0);
    vec_ready = 1'b1;
    @(negedge clk);
    chk("R7 consumed", vec_valid, 0);
    wr(0, 8'h00); set_irq(8'h00);

    // R6 spacing 8
    wr(0, 8'h84);
    set_irq(8'h04); ack();
    chk("R6 vector", vec_data, 16'h1250);
    wr(0, 8'h00); set_irq(8'h00);

    // R8 rotation
    wr(0, 8'h81);
    set_irq(8'h03); ack();
    chk("R8 first", vec_data, BASE);
    wr(0, 8'h00);
    set_irq(8'h02); set_irq(8'h03); ack();
    chk("R8 served level drops", vec_data, BASE | 16'h0004);
    wr(0, 8'h00); ack();
    chk("R8 rotated again", vec_data, BASE);
    wr(0, 8'h00); set_irq(8'h00);

    // R9 specific lowest = 3
    wr(0, 8'hB2);
    set_irq(8'h24); ack();
    chk("R9 level 5 first", vec_data, BASE | 16'h0014);
    wr(0, 8'h00); ack();
    chk("R9 level 2 next", vec_data, BASE | 16'h0008);
    wr(0, 8'h00); set_irq(8'h00);

    // R10 polled
    wr(0, 8'h83);
    set_irq(8'h50);
    chk("R10 no irq", irq_out, 0);
    rd(0, d); chk("R10 poll 4", d, 8'h84);
    rd(0, d); chk("R10 poll 6", d, 8'h86);
    rd(0, d); chk("R10 poll empty", d, 8'h00);
    wr(0, 8'h00); wr(0, 8'h00);
    set_irq(8'h00); wr(0, 8'h80);

    finish_run();
  end
endmodule